// File: doc/BRIEF.md
# Switch-Point Relocation Wrapper

This block wraps a hardware task so that a host can move the task to a processor and back while it runs. The host raises a relocation request whenever it wants. The wrapper synchronizes and latches the request and lets the task keep running. It halts the task only when the task signals that it sits at one of its designer-defined switch points. It then streams out a header and the context words that belong to that switch point. Each switch point has its own word count, and that count may be zero. It then reports that the hand-over is complete.

The task is started or resumed through a restore stream. The host sends a header naming a switch point and its word count, then that many context words. The wrapper checks the header against its per-switch-point size table and writes the words into the task's context storage. It then releases the task with a one-cycle resume pulse and the switch-point number. A header that names an unknown switch point or gives the wrong count is rejected and the task stays stopped.

Top module: `task_reloc_wrap`

## Requirements
- R1: After reset the task is stopped (task_run_o low), reloc_done_o, restore_err_o, sv_valid_o and task_resume_o are low, and rs_ready_o is high.
- R2: A restore header word carries the word count in bits [3:0] and the switch-point number in bits [5:4], with the other bits zero. Default sizes are 0 words for switch point 0, 3 for switch point 1 and 1 for switch point 2. An accepted header with a matching count of zero starts the task on the next cycle: task_run_o high, task_resume_o high for exactly one cycle, and sp_id_o equal to the header's switch point.
- R3: An accepted header with a nonzero count is followed by that many words. Each word is written to the task context with ctx_wr_idx_o counting 0, 1, 2 in arrival order. The task resumes, with the resume pulse, on the cycle after the last word.
- R4: A header whose switch point is not in the table (number 3 by default), or whose count differs from the table entry, sets restore_err_o and leaves the task stopped with no context write. The next valid header clears restore_err_o.
- R5: reloc_req_i is asynchronous. A rising edge is synchronized and held, even when it arrives while the task is stopped. The task keeps running with the request pending until it reports a switch point.
- R6: With a request pending, a cycle with task_sp_hit_i high stops the task on the next cycle, and sp_id_o shows the reported switch point. Without a pending request, task_sp_hit_i has no effect.
- R7: For a switch point with a nonzero count, the save stream sends the header (same format as R2) and then the context words read through ctx_rd_idx_o in index order 0 upward. A word offered while sv_ready_i is low stays valid and unchanged.
- R8: For a switch point whose count is zero, no save stream word is offered, and reloc_done_o rises directly.
- R9: A relocation request edge that arrives while the save stream is active is discarded. After the next restore, the task ignores switch points.
- R10: reloc_done_o stays high after the save until the host presents a restore header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reloc_req_i | input | 1 | Asynchronous relocation request from the host |
| task_sp_hit_i | input | 1 | Task reports it is at a switch point |
| task_sp_id_i | input | 2 | Number of the switch point the task is at |
| task_run_o | output | 1 | Task is allowed to advance |
| task_resume_o | output | 1 | One-cycle pulse: task resumes at sp_id_o |
| sp_id_o | output | 2 | Switch point of the last save or restore |
| ctx_rd_idx_o | output | 4 | Context word index read during a save |
| ctx_rd_data_i | input | 16 | Task context word at ctx_rd_idx_o |
| ctx_wr_en_o | output | 1 | Context word write strobe during a restore |
| ctx_wr_idx_o | output | 4 | Context word index written |
| ctx_wr_data_o | output | 16 | Context word written |
| sv_valid_o | output | 1 | Save stream word valid |
| sv_ready_i | input | 1 | Save stream sink ready |
| sv_data_o | output | 16 | Save stream word |
| rs_valid_i | input | 1 | Restore stream word valid |
| rs_ready_o | output | 1 | Restore stream accepts words |
| rs_data_i | input | 16 | Restore stream word |
| reloc_done_o | output | 1 | Context handed over, task stopped |
| restore_err_o | output | 1 | Last restore header was rejected |

## Verification
The bench targets the cases where a design could stop the task too early. It holds a request for many cycles before the switch point, and it reports a switch point with no request pending. A wrong design would drop task_run_o at once. The bench stalls the save stream to catch a header that changes or vanishes under backpressure. It uses a zero-size switch point, where a careless design would emit a stray header or hang in the save state. Requests raised while the task is stopped must survive, and requests raised mid-save must vanish. Both unknown switch-point numbers and count mismatches must raise the error without any context write or start of the task.

// File: rtl/reloc_wrap_pkg.sv
package reloc_wrap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_PENDING,
    ST_INTR,
    ST_SAVE,
    ST_DONE,
    ST_RESTORE
  } wrap_state_e;
endpackage

// File: rtl/reloc_req_sync.sv
module reloc_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async_i,
  output logic req_pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], req_async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign req_pulse_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sp_word_table.sv
module sp_word_table #(
  parameter int                      NUM_SP   = 3,
  parameter int                      ID_W     = 2,
  parameter int                      CNT_W    = 4,
  parameter logic [NUM_SP*CNT_W-1:0] SP_WORDS = 12'h130
) (
  input  logic [ID_W-1:0]  id_i,
  output logic             known_o,
  output logic [CNT_W-1:0] words_o
);
  logic [CNT_W-1:0] size_arr [NUM_SP];

  for (genvar g = 0; g < NUM_SP; g++) begin : g_entry
    assign size_arr[g] = SP_WORDS[g*CNT_W +: CNT_W];
  end

  always_comb begin
    known_o = 1'b0;
    words_o = '0;
    for (int i = 0; i < NUM_SP; i++) begin
      if (id_i == ID_W'(i)) begin
        known_o = 1'b1;
        words_o = size_arr[i];
      end
    end
  end
endmodule

// File: rtl/reloc_fsm.sv
module reloc_fsm
  import reloc_wrap_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_pulse_i,
  input  logic              sp_hit_i,
  input  logic [ID_W-1:0]   sp_id_i,
  input  logic              sv_known_i,
  input  logic [CNT_W-1:0]  sv_cnt_i,
  input  logic              hdr_ok_i,
  input  logic [ID_W-1:0]   hdr_id_i,
  input  logic [CNT_W-1:0]  hdr_cnt_i,
  output logic              task_run_o,
  output logic              task_resume_o,
  output logic [ID_W-1:0]   sp_id_o,
  output logic [CNT_W-1:0]  ctx_rd_idx_o,
  input  logic [DATA_W-1:0] ctx_rd_data_i,
  output logic              ctx_wr_en_o,
  output logic [CNT_W-1:0]  ctx_wr_idx_o,
  output logic [DATA_W-1:0] ctx_wr_data_o,
  output logic              sv_valid_o,
  input  logic              sv_ready_i,
  output logic [DATA_W-1:0] sv_data_o,
  input  logic              rs_valid_i,
  output logic              rs_ready_o,
  input  logic [DATA_W-1:0] rs_data_i,
  output logic              reloc_done_o,
  output logic              restore_err_o
);
  wrap_state_e      state_q, state_d;
  logic [ID_W-1:0]  sp_q, sp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             err_q, err_d;
  logic             latch_q, latch_d;
  logic             resume_q, resume_d;
  logic [DATA_W-1:0] sv_hdr;

  always_comb begin
    state_d  = state_q;
    sp_d     = sp_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    err_d    = err_q;
    resume_d = 1'b0;
    latch_d  = latch_q | (req_pulse_i && state_q != ST_SAVE);
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (rs_valid_i) begin
          if (hdr_ok_i) begin
            err_d = 1'b0;
            sp_d  = hdr_id_i;
            cnt_d = hdr_cnt_i;
            idx_d = '0;
            if (hdr_cnt_i == '0) begin
              state_d  = ST_RUN;
              resume_d = 1'b1;
            end else begin
              state_d = ST_RESTORE;
            end
          end else begin
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_RESTORE: begin
        if (rs_valid_i) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == cnt_q - 1'b1) begin
            state_d  = ST_RUN;
            resume_d = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (latch_q) state_d = ST_PENDING;
      end
      ST_PENDING: begin
        if (sp_hit_i) begin
          state_d = ST_INTR;
          sp_d    = sp_id_i;
          cnt_d   = sv_known_i ? sv_cnt_i : '0;
          idx_d   = '0;
          latch_d = 1'b0;
        end
      end
      ST_INTR: begin
        state_d = (cnt_q == '0) ? ST_DONE : ST_SAVE;
      end
      ST_SAVE: begin
        if (sv_ready_i) begin
          if (idx_q == cnt_q) state_d = ST_DONE;
          else                idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sp_q     <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      err_q    <= 1'b0;
      latch_q  <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      sp_q     <= sp_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      err_q    <= err_d;
      latch_q  <= latch_d;
      resume_q <= resume_d;
    end
  end

  always_comb begin
    sv_hdr                = '0;
    sv_hdr[CNT_W-1:0]     = cnt_q;
    sv_hdr[CNT_W +: ID_W] = sp_q;
  end

  assign task_run_o    = (state_q == ST_RUN) || (state_q == ST_PENDING);
  assign task_resume_o = resume_q;
  assign sp_id_o       = sp_q;
  assign rs_ready_o    = (state_q == ST_IDLE) || (state_q == ST_DONE) ||
                         (state_q == ST_RESTORE);
  assign sv_valid_o    = (state_q == ST_SAVE);
  assign sv_data_o     = (idx_q == '0) ? sv_hdr : ctx_rd_data_i;
  assign ctx_rd_idx_o  = (idx_q == '0) ? '0 : idx_q - 1'b1;
  assign ctx_wr_en_o   = (state_q == ST_RESTORE) && rs_valid_i;
  assign ctx_wr_idx_o  = idx_q;
  assign ctx_wr_data_o = rs_data_i;
  assign reloc_done_o  = (state_q == ST_DONE);
  assign restore_err_o = err_q;

  // R7
  sv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sv_valid_o && !sv_ready_i |=> sv_valid_o && $stable(sv_data_o));

  // R6
  halt_at_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(task_run_o) |-> $past(sp_hit_i));

  // R4
  bad_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_ready_o && rs_valid_i && state_q != ST_RESTORE && !hdr_ok_i)
      |=> restore_err_o && !task_run_o && !ctx_wr_en_o);

  // R3
  wr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_wr_en_o |-> ctx_wr_idx_o < cnt_q);

  // R2
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_resume_o |-> task_run_o && $past(rs_valid_i));

  // R8
  zero_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INTR && cnt_q == '0) |=> reloc_done_o && !sv_valid_o);
endmodule

// File: rtl/task_reloc_wrap.sv
module task_reloc_wrap #(
  parameter int                      NUM_SP   = 3,
  parameter int                      ID_W     = 2,
  parameter int                      CNT_W    = 4,
  parameter int                      DATA_W   = 16,
  parameter int                      SYNC_STG = 2,
  parameter logic [NUM_SP*CNT_W-1:0] SP_WORDS = 12'h130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reloc_req_i,
  input  logic              task_sp_hit_i,
  input  logic [ID_W-1:0]   task_sp_id_i,
  output logic              task_run_o,
  output logic              task_resume_o,
  output logic [ID_W-1:0]   sp_id_o,
  output logic [CNT_W-1:0]  ctx_rd_idx_o,
  input  logic [DATA_W-1:0] ctx_rd_data_i,
  output logic              ctx_wr_en_o,
  output logic [CNT_W-1:0]  ctx_wr_idx_o,
  output logic [DATA_W-1:0] ctx_wr_data_o,
  output logic              sv_valid_o,
  input  logic              sv_ready_i,
  output logic [DATA_W-1:0] sv_data_o,
  input  logic              rs_valid_i,
  output logic              rs_ready_o,
  input  logic [DATA_W-1:0] rs_data_i,
  output logic              reloc_done_o,
  output logic              restore_err_o
);
  localparam int HDR_W = ID_W + CNT_W;

  logic             req_pulse;
  logic             sv_known, hdr_known, hdr_ok, hdr_pad_zero;
  logic [CNT_W-1:0] sv_cnt, hdr_tab_cnt, hdr_cnt;
  logic [ID_W-1:0]  hdr_id;

  assign hdr_cnt      = rs_data_i[CNT_W-1:0];
  assign hdr_id       = rs_data_i[CNT_W +: ID_W];
  assign hdr_pad_zero = (rs_data_i >> HDR_W) == '0;
  assign hdr_ok       = hdr_known && hdr_pad_zero && (hdr_tab_cnt == hdr_cnt);

  reloc_req_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_async_i (reloc_req_i),
    .req_pulse_o (req_pulse)
  );

  sp_word_table #(.NUM_SP(NUM_SP), .ID_W(ID_W), .CNT_W(CNT_W), .SP_WORDS(SP_WORDS))
    u_tab_save (.id_i(task_sp_id_i), .known_o(sv_known), .words_o(sv_cnt));

  sp_word_table #(.NUM_SP(NUM_SP), .ID_W(ID_W), .CNT_W(CNT_W), .SP_WORDS(SP_WORDS))
    u_tab_rest (.id_i(hdr_id), .known_o(hdr_known), .words_o(hdr_tab_cnt));

  reloc_fsm #(.ID_W(ID_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_pulse_i   (req_pulse),
    .sp_hit_i      (task_sp_hit_i),
    .sp_id_i       (task_sp_id_i),
    .sv_known_i    (sv_known),
    .sv_cnt_i      (sv_cnt),
    .hdr_ok_i      (hdr_ok),
    .hdr_id_i      (hdr_id),
    .hdr_cnt_i     (hdr_cnt),
    .task_run_o    (task_run_o),
    .task_resume_o (task_resume_o),
    .sp_id_o       (sp_id_o),
    .ctx_rd_idx_o  (ctx_rd_idx_o),
    .ctx_rd_data_i (ctx_rd_data_i),
    .ctx_wr_en_o   (ctx_wr_en_o),
    .ctx_wr_idx_o  (ctx_wr_idx_o),
    .ctx_wr_data_o (ctx_wr_data_o),
    .sv_valid_o    (sv_valid_o),
    .sv_ready_i    (sv_ready_i),
    .sv_data_o     (sv_data_o),
    .rs_valid_i    (rs_valid_i),
    .rs_ready_o    (rs_ready_o),
    .rs_data_i     (rs_data_i),
    .reloc_done_o  (reloc_done_o),
    .restore_err_o (restore_err_o)
  );
endmodule

// File: tb/tb_task_reloc_wrap.sv
module tb_task_reloc_wrap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reloc_req = 1'b0, sp_hit = 1'b0, sv_ready = 1'b1, rs_valid = 1'b0;
  logic [1:0]  sp_id_in = '0;
  logic [15:0] rs_data = '0, ctx_base = '0;
  logic        run, resume, ctx_wr_en, sv_valid, rs_ready, done, err;
  logic [1:0]  sp_id;
  logic [3:0]  ctx_rd_idx, ctx_wr_idx;
  logic [15:0] ctx_rd_data, ctx_wr_data, sv_data;

  int n_chk = 0, n_bad = 0, sv_seen = 0;
  bit finished = 1'b0;
  logic [15:0] sv_q [$];
  logic [19:0] wr_q [$];

  always #10 clk = ~clk;
  assign ctx_rd_data = ctx_base + 16'(ctx_rd_idx);

  task_reloc_wrap dut (
    .clk(clk), .rst_n(rst_n), .reloc_req_i(reloc_req),
    .task_sp_hit_i(sp_hit), .task_sp_id_i(sp_id_in),
    .task_run_o(run), .task_resume_o(resume), .sp_id_o(sp_id),
    .ctx_rd_idx_o(ctx_rd_idx), .ctx_rd_data_i(ctx_rd_data),
    .ctx_wr_en_o(ctx_wr_en), .ctx_wr_idx_o(ctx_wr_idx), .ctx_wr_data_o(ctx_wr_data),
    .sv_valid_o(sv_valid), .sv_ready_i(sv_ready), .sv_data_o(sv_data),
    .rs_valid_i(rs_valid), .rs_ready_o(rs_ready), .rs_data_i(rs_data),
    .reloc_done_o(done), .restore_err_o(err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (sv_valid) sv_seen++;
      if (sv_valid && sv_ready) begin
        if (sv_q.size() == 0) check(1'b0, "R7 extra save word", 32'(sv_data), 32'hffff);
        else begin
          logic [15:0] e;
          e = sv_q.pop_front();
          check(sv_data == e, "R7 save word", 32'(sv_data), 32'(e));
        end
      end
      if (ctx_wr_en) begin
        if (wr_q.size() == 0) check(1'b0, "R3 extra write", 32'({ctx_wr_idx, ctx_wr_data}), 32'hfffff);
        else begin
          logic [19:0] e;
          e = wr_q.pop_front();
          check({ctx_wr_idx, ctx_wr_data} == e, "R3 context write",
                32'({ctx_wr_idx, ctx_wr_data}), 32'(e));
        end
      end
    end
  end

  function automatic logic [15:0] hdr(input logic [1:0] id, input logic [3:0] cnt);
    return {10'd0, id, cnt};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic restore(input logic [1:0] id, input logic [3:0] cnt,
                         input logic [15:0] base, input int nwords);
    cyc(1);
    rs_valid = 1'b1;
    rs_data  = hdr(id, cnt);
    for (int k = 0; k < nwords; k++) begin
      cyc(1);
      rs_data = base + 16'(k);
      wr_q.push_back({4'(k), base + 16'(k)});
    end
    cyc(1);
    rs_valid = 1'b0;
  endtask

  task automatic pulse_req();
    cyc(1);
    reloc_req = 1'b1;
    cyc(3);
    reloc_req = 1'b0;
  endtask

  task automatic hit(input logic [1:0] id);
    cyc(1);
    sp_hit = 1'b1;
    sp_id_in = id;
    cyc(1);
    sp_hit = 1'b0;
  endtask

  task automatic expect_save(input logic [1:0] id, input logic [3:0] cnt,
                             input logic [15:0] base);
    sv_q.push_back(hdr(id, cnt));
    for (int k = 0; k < int'(cnt); k++) sv_q.push_back(base + 16'(k));
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!run && !done && !err && !sv_valid && !resume, "R1 outputs idle",
          {27'd0, run, done, err, sv_valid, resume}, 0);
    check(rs_ready, "R1 restore ready", 32'(rs_ready), 1);

    // R2 launch at switch point 0
    restore(2'd0, 4'd0, 16'h0, 0);
    @(negedge clk);
    check(run && resume && sp_id == 2'd0, "R2 launch", {29'd0, run, resume, 1'b0}, 32'h6);
    @(negedge clk);
    check(run && !resume, "R2 resume single cycle", {30'd0, run, resume}, 32'h2);

    // R6 switch point without request
    cyc(10);
    hit(2'd1);
    @(negedge clk);
    check(run, "R6 hit without request ignored", 32'(run), 1);

    // R5 request held while running, R6 halt, R7 stalled save
    ctx_base = 16'h1200;
    pulse_req();
    cyc(8);
    @(negedge clk);
    check(run, "R5 runs until switch point", 32'(run), 1);
    sv_ready = 1'b0;
    expect_save(2'd1, 4'd3, 16'h1200);
    hit(2'd1);
    @(negedge clk);
    check(!run && sp_id == 2'd1, "R6 halt at switch point", {29'd0, run, sp_id}, 32'h1);
    cyc(4);
    @(negedge clk);
    check(sv_valid && sv_data == hdr(2'd1, 4'd3), "R7 header held under stall",
          32'(sv_data), 32'(hdr(2'd1, 4'd3)));
    cyc(1);
    sv_ready = 1'b1;
    wait_done();
    check(done, "R10 done after save", 32'(done), 1);
    cyc(5);
    @(negedge clk);
    check(done && !run, "R10 done held", {30'd0, done, run}, 32'h2);
    check(sv_q.size() == 0, "R7 all save words seen", sv_q.size(), 0);

    // R3 restore with three words
    restore(2'd1, 4'd3, 16'h0a00, 3);
    @(negedge clk);
    check(run && resume && !done, "R3 resume after words", {29'd0, run, resume, done}, 32'h6);
    check(wr_q.size() == 0, "R3 all writes seen", wr_q.size(), 0);

    // R8 zero-size switch point
    pulse_req();
    cyc(8);
    sv_seen = 0;
    hit(2'd0);
    wait_done();
    check(done && sv_seen == 0, "R8 straight to done", sv_seen, 0);

    // R5 request raised while stopped is held
    pulse_req();
    cyc(8);
    restore(2'd2, 4'd1, 16'h0300, 1);
    @(negedge clk);
    check(run, "R3 single word restore", 32'(run), 1);
    ctx_base = 16'h5500;
    sv_ready = 1'b0;
    expect_save(2'd2, 4'd1, 16'h5500);
    hit(2'd2);
    @(negedge clk);
    check(!run, "R5 request held across stop", 32'(run), 0);

    // R9 request during save ignored
    cyc(3);
    pulse_req();
    cyc(6);
    sv_ready = 1'b1;
    wait_done();
    check(done && sv_q.size() == 0, "R9 save completes", sv_q.size(), 0);
    restore(2'd0, 4'd0, 16'h0, 0);
    cyc(10);
    hit(2'd1);
    @(negedge clk);
    check(run, "R9 request during save discarded", 32'(run), 1);

    // R4 bad headers
    pulse_req();
    cyc(8);
    hit(2'd0);
    wait_done();
    restore(2'd3, 4'd0, 16'h0, 0);
    @(negedge clk);
    check(err && !run && !done, "R4 unknown switch point", {29'd0, err, run, done}, 32'h4);
    restore(2'd1, 4'd2, 16'h0, 0);
    @(negedge clk);
    check(err && !run, "R4 count mismatch", {30'd0, err, run}, 32'h2);
    restore(2'd0, 4'd0, 16'h0, 0);
    @(negedge clk);
    check(!err && run, "R4 error cleared by good header", {30'd0, err, run}, 32'h1);
    check(wr_q.size() == 0, "R4 no writes on bad header", wr_q.size(), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule